// File: doc/BRIEF.md
# Serial Real-Time Clock with Parameter RAM

This block is the device side of a three-wire serial link to a clock chip. The host holds an active-low enable low, toggles a serial clock, and moves data over a single data line. Here that line is split into an input, an output and an output-enable, and the pad logic combines them. The block holds a 32-bit seconds counter and 256 bytes of parameter RAM. The counter advances once for each pulse on a one-second tick input, and its value counts seconds from an epoch at the start of 1904.

Each transaction starts with a one-byte command. Bit 7 of the command gives the direction, and the low seven bits pick the target. A short read returns one byte. A short write takes one data byte after the command. Extended commands reach the full RAM as eight sectors of 32 bytes. An extended read takes a command byte and an address byte, then returns one byte. An extended write takes a command byte, an address byte and a data byte.

A write-protect latch blocks RAM writes. A byte that matches no command pattern produces a one-cycle report pulse and is dropped. All link inputs are assumed synchronous to `clk` and slow relative to it, so the block detects serial clock edges by comparing the serial clock with its value one cycle earlier.

Top module: `serial_rtc`

## Requirements
- R1: After reset, `serDoe` and `cmdBad` are low, no command is pending, and the seconds counter holds `RESET_SECS` (default 0).
- R2: Bits are taken from `serDin` on rising `serClk` edges, most significant bit first. After a byte that completes a read, the block raises `serDoe` after the next falling edge. It then presents the result MSB first for exactly 8 clocks, advancing one bit after each falling edge. After the 8th falling edge it drops `serDoe` and waits for a new command.
- R3: Read command `1000ss01` returns byte ss of the seconds counter, where ss=0 is the least significant byte. Each `secTick` pulse adds one to the counter.
- R4: Write commands `0000ss01` and `00110001` (test register) consume one data byte and change nothing.
- R5: Command `z1aaaa01` reads (z=1) or writes (z=0) RAM byte aaaa, which is address 0x00 to 0x0F.
- R6: Command `z010aa01` reads or writes RAM byte 0x10+aa.
- R7: Command `z0111sss` selects sector sss. The next byte carries a 5-bit offset in bits 6:2, and the RAM address is sss*32+offset. For a read, the block then returns that byte. For a write, a third byte supplies the data. The extended and short commands address the same RAM.
- R8: Writing command `00110101` sets the write-protect flag to bit 7 of the data byte. While the flag is set, RAM writes of either form are consumed but have no effect. Writes to the write-protect register itself always take effect.
- R9: Read commands `10110001` and `10110101`, and any byte matching no pattern in R3 to R8, raise `cmdBad` for one cycle. The byte is dropped, and the next byte is taken as a new command.
- R10: Raising `serEnN` abandons any partial byte, any pending command or address, and any read in progress. `serDoe` falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse per elapsed second |
| serEnN | input | 1 | Active-low link enable from host |
| serClk | input | 1 | Serial clock driven by host |
| serDin | input | 1 | Serial data from host |
| serDout | output | 1 | Serial data to host, valid while serDoe is high |
| serDoe | output | 1 | High while the block drives the data line |
| cmdBad | output | 1 | One-cycle pulse for a discarded command byte |

## Verification
The bound checker watches these properties on every cycle:
- `serDoe` falls right after the enable is released, and it rises only after a falling serial clock.
- `serDout` holds steady while the serial clock stays high.
- `cmdBad` is a single-cycle pulse that never overlaps a read and only occurs while the link is enabled.

The bench scenarios cover what the checker cannot see:
- command decoding across all regions, and aliasing between sector and short addresses
- the write-protect latch, including writes to its own register
- seconds byte order and the inertness of writes to the seconds and test registers
- recovery after an abort in the middle of a byte, an extended write or a read

// File: rtl/serial_rtc_pkg.sv
package serial_rtc_pkg;

  localparam int SectCount = 8;
  localparam int SectBytes = 32;
  localparam int RamDepth  = SectCount * SectBytes;
  localparam int RamAw     = $clog2(RamDepth);
  localparam int SectAw    = $clog2(SectCount);
  localparam int OffAw     = $clog2(SectBytes);
  localparam int SecsWidth = 32;
  localparam int SecsBytes = SecsWidth / 8;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_SECS,
    TGT_TEST,
    TGT_WPROT,
    TGT_RAM,
    TGT_SECT
  } tgt_e;

  typedef struct packed {
    logic             valid;
    logic             isRead;
    tgt_e             tgt;
    logic [RamAw-1:0] idx;
  } cmd_t;

  typedef struct packed {
    logic             ramWr;
    logic             wpWr;
    logic [RamAw-1:0] ramAddr;
    logic [7:0]       wrByte;
    logic             loadRd;
    logic             rdSecs;
    logic [1:0]       secIdx;
    logic             shiftRd;
  } strobe_t;

  function automatic cmd_t decodeCmd(input logic [7:0] b);
    cmd_t       c;
    logic [4:0] w;
    c.valid  = 1'b0;
    c.isRead = b[7];
    c.tgt    = TGT_NONE;
    c.idx    = '0;
    w        = b[6:2];
    if (b[6:3] == 4'b0111) begin
      c.valid = 1'b1;
      c.tgt   = TGT_SECT;
      c.idx   = RamAw'(b[2:0]);
    end else if (b[1:0] == 2'b01) begin
      if (w[4:2] == 3'b000) begin
        c.valid = 1'b1;
        c.tgt   = TGT_SECS;
        c.idx   = RamAw'(w[1:0]);
      end else if (w == 5'h0C && !b[7]) begin
        c.valid = 1'b1;
        c.tgt   = TGT_TEST;
      end else if (w == 5'h0D && !b[7]) begin
        c.valid = 1'b1;
        c.tgt   = TGT_WPROT;
      end else if (w[4:2] == 3'b010) begin
        c.valid = 1'b1;
        c.tgt   = TGT_RAM;
        c.idx   = RamAw'({3'b100, w[1:0]});
      end else if (w[4]) begin
        c.valid = 1'b1;
        c.tgt   = TGT_RAM;
        c.idx   = RamAw'(w[3:0]);
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/serial_rtc_ctrl.sv
module serial_rtc_ctrl
  import serial_rtc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    serEnN,
  input  logic    serClk,
  input  logic    serDin,
  output strobe_t stb,
  output logic    rdOe,
  output logic    cmdBad
);

  typedef enum logic [1:0] {ST_RX, ST_ARM, ST_OUT} st_e;

  st_e              st, stNext;
  logic             clkPrev;
  logic [2:0]       bitCnt, bitCntNext;
  logic [2:0]       rdCnt, rdCntNext;
  logic [7:0]       shiftIn;
  cmd_t             pendCmd, pendCmdNext;
  logic             altValid, altValidNext;
  logic [OffAw-1:0] altOff, altOffNext;
  logic             badNext;

  logic       rise, fall, byteDone;
  logic [7:0] newByte;
  cmd_t       dec;

  assign rise     = serClk && !clkPrev && !serEnN;
  assign fall     = !serClk && clkPrev && !serEnN;
  assign byteDone = (st == ST_RX) && rise && (bitCnt == 3'd7);
  assign newByte  = {shiftIn[6:0], serDin};
  assign dec      = decodeCmd(newByte);

  always_comb begin
    stb          = '0;
    stNext       = st;
    bitCntNext   = bitCnt;
    rdCntNext    = rdCnt;
    pendCmdNext  = pendCmd;
    altValidNext = altValid;
    altOffNext   = altOff;
    badNext      = 1'b0;
    stb.wrByte   = newByte;
    if (serEnN) begin
      stNext       = ST_RX;
      bitCntNext   = '0;
      rdCntNext    = '0;
      pendCmdNext  = '0;
      altValidNext = 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (rise) bitCntNext = bitCnt + 3'd1;
          if (byteDone) begin
            if (!pendCmd.valid) begin
              if (!dec.valid) begin
                badNext = 1'b1;
              end else if (dec.isRead && dec.tgt != TGT_SECT) begin
                stb.loadRd  = 1'b1;
                stb.rdSecs  = (dec.tgt == TGT_SECS);
                stb.secIdx  = dec.idx[1:0];
                stb.ramAddr = dec.idx;
                stNext      = ST_ARM;
              end else begin
                pendCmdNext = dec;
              end
            end else if (!altValid) begin
              pendCmdNext = '0;
              unique case (pendCmd.tgt)
                TGT_WPROT: stb.wpWr = 1'b1;
                TGT_RAM: begin
                  stb.ramWr   = 1'b1;
                  stb.ramAddr = pendCmd.idx;
                end
                TGT_SECT: begin
                  if (pendCmd.isRead) begin
                    stb.loadRd  = 1'b1;
                    stb.ramAddr = {pendCmd.idx[SectAw-1:0], newByte[6:2]};
                    stNext      = ST_ARM;
                  end else begin
                    pendCmdNext  = pendCmd;
                    altValidNext = 1'b1;
                    altOffNext   = newByte[6:2];
                  end
                end
                default: ;
              endcase
            end else begin
              stb.ramWr    = 1'b1;
              stb.ramAddr  = {pendCmd.idx[SectAw-1:0], altOff};
              pendCmdNext  = '0;
              altValidNext = 1'b0;
            end
          end
        end
        ST_ARM: begin
          if (fall) begin
            stNext    = ST_OUT;
            rdCntNext = '0;
          end
        end
        ST_OUT: begin
          if (fall) begin
            if (rdCnt == 3'd7) begin
              stNext     = ST_RX;
              bitCntNext = '0;
            end else begin
              stb.shiftRd = 1'b1;
              rdCntNext   = rdCnt + 3'd1;
            end
          end
        end
        default: stNext = ST_RX;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_RX;
      clkPrev  <= 1'b0;
      bitCnt   <= '0;
      rdCnt    <= '0;
      shiftIn  <= '0;
      pendCmd  <= '0;
      altValid <= 1'b0;
      altOff   <= '0;
      cmdBad   <= 1'b0;
    end else begin
      st       <= stNext;
      clkPrev  <= serClk;
      bitCnt   <= bitCntNext;
      rdCnt    <= rdCntNext;
      if (st == ST_RX && rise) shiftIn <= newByte;
      pendCmd  <= pendCmdNext;
      altValid <= altValidNext;
      altOff   <= altOffNext;
      cmdBad   <= badNext;
    end
  end

  assign rdOe = (st == ST_OUT);

endmodule

// File: rtl/serial_rtc_datapath.sv
module serial_rtc_datapath
  import serial_rtc_pkg::*;
#(
  parameter logic [SecsWidth-1:0] RESET_SECS = '0
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    secTick,
  input  strobe_t stb,
  output logic    rdBit
);

  logic [SecsWidth-1:0] secs;
  logic [7:0]           ram [RamDepth];
  logic                 wpFlag;
  logic [7:0]           rdShift;
  logic [7:0]           secsByte;

  always_comb begin
    secsByte = '0;
    for (int i = 0; i < SecsBytes; i++) begin
      if (stb.secIdx == 2'(i)) secsByte = secs[i*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secs    <= RESET_SECS;
      wpFlag  <= 1'b0;
      rdShift <= '0;
    end else begin
      if (secTick) secs <= secs + 1'b1;
      if (stb.wpWr) wpFlag <= stb.wrByte[7];
      if (stb.loadRd) rdShift <= stb.rdSecs ? secsByte : ram[stb.ramAddr];
      else if (stb.shiftRd) rdShift <= {rdShift[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (stb.ramWr && !wpFlag) ram[stb.ramAddr] <= stb.wrByte;
  end

  assign rdBit = rdShift[7];

endmodule

// File: rtl/serial_rtc.sv
module serial_rtc
  import serial_rtc_pkg::*;
#(
  parameter logic [31:0] RESET_SECS = 32'd0
) (
  input  logic clk,
  input  logic rstN,
  input  logic secTick,
  input  logic serEnN,
  input  logic serClk,
  input  logic serDin,
  output logic serDout,
  output logic serDoe,
  output logic cmdBad
);

  strobe_t stb;
  logic    rdBit;
  logic    rdOe;

  serial_rtc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .serEnN (serEnN),
    .serClk (serClk),
    .serDin (serDin),
    .stb    (stb),
    .rdOe   (rdOe),
    .cmdBad (cmdBad)
  );

  serial_rtc_datapath #(.RESET_SECS(RESET_SECS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .secTick (secTick),
    .stb     (stb),
    .rdBit   (rdBit)
  );

  assign serDoe  = rdOe;
  assign serDout = rdOe & rdBit;

endmodule

// File: rtl/serial_rtc_chk.sv
module serial_rtc_chk (
  input logic clk,
  input logic rstN,
  input logic secTick,
  input logic serEnN,
  input logic serClk,
  input logic serDin,
  input logic serDout,
  input logic serDoe,
  input logic cmdBad
);

  // R10
  en_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    serEnN |=> !serDoe);

  // R10
  oe_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    serDoe |-> $past(!serEnN));

  // R2
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serDoe) |-> $past(!serClk));

  // R2
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serDoe && $past(serDoe) && $past(serClk)) |-> $stable(serDout));

  // R9
  bad_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdBad |=> !cmdBad);

  // R9
  bad_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdBad |-> (!serDoe && $past(!serEnN)));

endmodule

bind serial_rtc serial_rtc_chk u_chk (.*);

// File: tb/serial_rtc_test.sv
module serial_rtc_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0;
  logic serEnN = 1'b1;
  logic serClk = 1'b0;
  logic serDin = 1'b0;
  logic serDout, serDoe, cmdBad;

  int nChecks = 0;
  int nFail = 0;
  int badPulses = 0;
  logic [31:0] secsModel = 32'd0;
  logic [7:0]  ramModel [256];

  always #4 clk = ~clk;

  serial_rtc uut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .serEnN(serEnN),
    .serClk(serClk), .serDin(serDin), .serDout(serDout),
    .serDoe(serDoe), .cmdBad(cmdBad)
  );

  always @(posedge clk) if (rstN && cmdBad) badPulses++;

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      serDin = b[i];
      waitClk(2);
      serClk = 1'b1;
      waitClk(3);
      serClk = 1'b0;
      waitClk(2);
    end
  endtask

  task automatic getByte(output logic [7:0] v, output bit oeOk);
    v = '0;
    oeOk = 1'b1;
    for (int i = 0; i < 8; i++) begin
      serClk = 1'b1;
      waitClk(3);
      v = {v[6:0], serDout};
      if (!serDoe) oeOk = 1'b0;
      serClk = 1'b0;
      waitClk(3);
    end
    waitClk(2);
    if (serDoe) oeOk = 1'b0;
  endtask

  task automatic enOn();
    serEnN = 1'b0;
    waitClk(2);
  endtask

  task automatic enOff();
    serClk = 1'b0;
    serEnN = 1'b1;
    waitClk(3);
  endtask

  task automatic wr2(input logic [7:0] c, input logic [7:0] d);
    enOn(); sendBits(c, 8); sendBits(d, 8); enOff();
  endtask

  task automatic rd1(input logic [7:0] c, output logic [7:0] v);
    bit ok;
    enOn(); sendBits(c, 8); getByte(v, ok); enOff();
    check(ok, "R2 drive window", {31'd0, ok}, 32'd1);
  endtask

  task automatic sectWr(input logic [2:0] s, input logic [4:0] o, input logic [7:0] d);
    enOn(); sendBits({5'b00111, s}, 8); sendBits({1'b0, o, 2'b00}, 8);
    sendBits(d, 8); enOff();
  endtask

  task automatic sectRd(input logic [2:0] s, input logic [4:0] o, output logic [7:0] v);
    bit ok;
    enOn(); sendBits({5'b10111, s}, 8); sendBits({1'b0, o, 2'b00}, 8);
    getByte(v, ok); enOff();
    check(ok, "R7 drive window", {31'd0, ok}, 32'd1);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      secTick = 1'b1; waitClk(1); secTick = 1'b0; waitClk(1);
      secsModel++;
    end
  endtask

  function automatic logic [7:0] lowCmd(input bit rd, input logic [3:0] a);
    return {rd, 1'b1, a, 2'b01};
  endfunction

  function automatic logic [7:0] highCmd(input bit rd, input logic [1:0] a);
    return {rd, 3'b010, a, 2'b01};
  endfunction

  function automatic logic [7:0] secCmd(input bit rd, input logic [1:0] s);
    return {rd, 3'b000, s, 2'b01};
  endfunction

  initial begin
    #(8 * 190000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    bit ok;
    int b0;
    void'($urandom(32'h1904_0101));
    waitClk(4);
    check(serDoe == 1'b0, "R1 serDoe at reset", {31'd0, serDoe}, 32'd0);
    check(cmdBad == 1'b0, "R1 cmdBad at reset", {31'd0, cmdBad}, 32'd0);
    rstN = 1'b1;
    waitClk(3);
    check(serDoe == 1'b0 && cmdBad == 1'b0, "R1 outputs idle after reset",
          {30'd0, serDoe, cmdBad}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      rd1(secCmd(1'b1, 2'(i)), v);
      check(v == 8'h00, "R1 R3 seconds start at zero", {24'd0, v}, 32'd0);
    end

    // R5 low region
    wr2(lowCmd(1'b0, 4'd5), 8'h5A); ramModel[5] = 8'h5A;
    rd1(lowCmd(1'b1, 4'd5), v);
    check(v == 8'h5A, "R5 low region readback", {24'd0, v}, 32'h5A);
    wr2(lowCmd(1'b0, 4'd15), 8'h81); ramModel[15] = 8'h81;
    sectRd(3'd0, 5'd15, v);
    check(v == 8'h81, "R5 R7 low byte via sector", {24'd0, v}, 32'h81);

    // R6 high region
    wr2(highCmd(1'b0, 2'd2), 8'hC3); ramModel[18] = 8'hC3;
    rd1(highCmd(1'b1, 2'd2), v);
    check(v == 8'hC3, "R6 high region readback", {24'd0, v}, 32'hC3);
    sectRd(3'd0, 5'd18, v);
    check(v == 8'hC3, "R6 R7 address 0x12 via sector", {24'd0, v}, 32'hC3);

    // R7 extended sector
    sectWr(3'd5, 5'd31, 8'hE7); ramModel[191] = 8'hE7;
    sectRd(3'd5, 5'd31, v);
    check(v == 8'hE7, "R7 sector 5 offset 31", {24'd0, v}, 32'hE7);
    sectWr(3'd7, 5'd0, 8'h3C); ramModel[224] = 8'h3C;
    sectRd(3'd7, 5'd0, v);
    check(v == 8'h3C, "R7 sector 7 offset 0", {24'd0, v}, 32'h3C);

    // R2 back-to-back transactions in one enable window
    enOn();
    sendBits(lowCmd(1'b0, 4'd9), 8); sendBits(8'h96, 8); ramModel[9] = 8'h96;
    sendBits(lowCmd(1'b1, 4'd9), 8); getByte(v, ok);
    check(ok, "R2 drive window back-to-back", {31'd0, ok}, 32'd1);
    check(v == 8'h96, "R2 read after write same window", {24'd0, v}, 32'h96);
    sendBits(lowCmd(1'b1, 4'd5), 8); getByte(v, ok);
    check(v == 8'h5A, "R2 second read same window", {24'd0, v}, 32'h5A);
    enOff();

    // R3 seconds counting and byte order
    tick(300);
    for (int i = 0; i < 4; i++) begin
      rd1(secCmd(1'b1, 2'(i)), v);
      check(v == secsModel[i*8 +: 8], "R3 seconds byte", {24'd0, v},
            {24'd0, secsModel[i*8 +: 8]});
    end

    // R4 seconds and test writes inert
    wr2(secCmd(1'b0, 2'd0), 8'hFF);
    wr2(secCmd(1'b0, 2'd1), 8'h77);
    wr2(8'h31, 8'hFF);
    rd1(secCmd(1'b1, 2'd0), v);
    check(v == secsModel[7:0], "R4 seconds byte 0 unchanged", {24'd0, v},
          {24'd0, secsModel[7:0]});
    rd1(secCmd(1'b1, 2'd1), v);
    check(v == secsModel[15:8], "R4 seconds byte 1 unchanged", {24'd0, v},
          {24'd0, secsModel[15:8]});
    rd1(lowCmd(1'b1, 4'd5), v);
    check(v == 8'h5A, "R4 RAM unchanged after test write", {24'd0, v}, 32'h5A);

    // R8 write protect
    wr2(8'h35, 8'h80);
    wr2(lowCmd(1'b0, 4'd5), 8'h11);
    sectWr(3'd5, 5'd31, 8'h22);
    wr2(highCmd(1'b0, 2'd2), 8'h33);
    rd1(lowCmd(1'b1, 4'd5), v);
    check(v == 8'h5A, "R8 protected short write ignored", {24'd0, v}, 32'h5A);
    sectRd(3'd5, 5'd31, v);
    check(v == 8'hE7, "R8 protected sector write ignored", {24'd0, v}, 32'hE7);
    rd1(highCmd(1'b1, 2'd2), v);
    check(v == 8'hC3, "R8 protected high write ignored", {24'd0, v}, 32'hC3);
    wr2(8'h35, 8'h7F);
    wr2(lowCmd(1'b0, 4'd5), 8'h44); ramModel[5] = 8'h44;
    rd1(lowCmd(1'b1, 4'd5), v);
    check(v == 8'h44, "R8 unprotect via own register", {24'd0, v}, 32'h44);

    // R9 invalid commands
    b0 = badPulses;
    enOn();
    sendBits(8'hB1, 8); waitClk(3);
    check(serDoe == 1'b0, "R9 no drive after read of test code", {31'd0, serDoe}, 32'd0);
    sendBits(8'hB5, 8);
    sendBits(8'h11, 8);
    sendBits(8'h02, 8);
    sendBits(lowCmd(1'b1, 4'd9), 8); getByte(v, ok);
    enOff();
    check(badPulses - b0 == 4, "R9 bad pulse count", 32'(badPulses - b0), 32'd4);
    check(v == 8'h96 && ok, "R9 next byte taken as command", {24'd0, v}, 32'h96);

    // R10 aborts
    enOn(); sendBits(lowCmd(1'b1, 4'd5), 5); enOff();
    rd1(lowCmd(1'b1, 4'd5), v);
    check(v == 8'h44, "R10 partial byte dropped", {24'd0, v}, 32'h44);
    enOn(); sendBits(8'h3D, 8); sendBits({1'b0, 5'd31, 2'b00}, 8); enOff();
    rd1(lowCmd(1'b1, 4'd9), v);
    check(v == 8'h96, "R10 pending sector write dropped", {24'd0, v}, 32'h96);
    sectRd(3'd5, 5'd31, v);
    check(v == 8'hE7, "R10 sector byte unchanged", {24'd0, v}, 32'hE7);
    enOn(); sendBits(lowCmd(1'b1, 4'd5), 8);
    for (int i = 0; i < 3; i++) begin
      serClk = 1'b1; waitClk(3); serClk = 1'b0; waitClk(3);
    end
    serEnN = 1'b1;
    waitClk(2);
    check(serDoe == 1'b0, "R10 read aborted releases line", {31'd0, serDoe}, 32'd0);
    waitClk(2);

    // random mix across regions
    for (int it = 0; it < 24; it++) begin
      int r;
      logic [7:0] a, d;
      r = int'($urandom % 3);
      d = 8'($urandom);
      if (r == 0) begin
        a = {4'd0, 4'($urandom)};
        wr2(lowCmd(1'b0, a[3:0]), d);
      end else if (r == 1) begin
        a = {6'b000100, 2'($urandom)};
        wr2(highCmd(1'b0, a[1:0]), d);
      end else begin
        a = 8'($urandom);
        sectWr(a[7:5], a[4:0], d);
      end
      ramModel[a] = d;
      if (($urandom % 2) == 0) tick(int'($urandom % 5));
      sectRd(a[7:5], a[4:0], v);
      check(v == ramModel[a], "R7 random readback", {24'd0, v}, {24'd0, ramModel[a]});
    end
    rd1(secCmd(1'b1, 2'd0), v);
    check(v == secsModel[7:0], "R3 seconds after random ticks", {24'd0, v},
          {24'd0, secsModel[7:0]});

    summary();
    $finish;
  end

endmodule